// File: doc/BRIEF.md
# TDM Channel Slot Selector

This block sits next to a serial port that carries a time-division-multiplexed stream. Each frame is a run of word-sized channel slots, up to 128 of them. The block counts the slots from the frame sync. For the slot in progress it tells the receive side whether to capture the word. It also tells the transmit side whether to drive the data pin; when the pin is not driven it floats. Slots that are not selected cause no data movement toward the host. The block does no bit shifting, companding or clock generation.

Selection is configured separately for each direction. Each direction has five banks of eight enable bits. Each bank carries a four-bit block index, which places its eight bits on any of the sixteen 8-channel blocks of the frame. At most 32 enables are honoured per direction. When more are set, the surplus is dropped and an over-limit flag is raised for that direction. The current channel number is exported for debug.

Top module: `tdm_slot_selector`

## Requirements
- R1: After reset, curChan is 0, slotValid is 0, and rxCapture and txDrive are 0.
- R2: A cycle with frameSync high sets curChan to 0 and slotValid to 1 at the next clock edge. This holds even if wordStrobe is also high in that cycle.
- R3: While slotValid is 1, a cycle with wordStrobe high and frameSync low raises curChan by one at the next edge. Without either strobe, curChan holds.
- R4: rxCapture is 1 exactly when slotValid is 1 and the current channel is enabled for receive. Bit k of receive bank b enables channel B*8+k, where B is the unsigned value of rxBankBlk[4b+3:4b] and the bit is rxBankEn[8b+k].
- R5: txDrive uses the same mapping on txBankEn and txBankBlk and is independent of the receive configuration. When txDrive is 0 the transmit pin is to be left in high impedance.
- R6: Before the first frameSync after reset, slotValid, rxCapture and txDrive stay 0 and wordStrobe does not move curChan.
- R7: When a direction has more than 32 enable bits set, its over-limit output (rxOverLimit or txOverLimit) is 1; with exactly 32 or fewer set, it is 0. Set bits are counted in order from bank 0 bit 0 upward through each bank and then to the next bank. Only the first 32 in that order take effect, whatever channels they map to.
- R8: A wordStrobe without frameSync while curChan is 127 clears slotValid and leaves curChan at 127. rxCapture and txDrive then stay 0 until the next frameSync.
- R9: When two banks of one direction name the same block, a channel in that block is enabled if either bank enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameSync | input | 1 | Frame start, one cycle, marks slot 0 |
| wordStrobe | input | 1 | Word boundary, one cycle, moves to the next slot |
| txBankEn | input | 40 | Transmit enable bits, eight per bank |
| txBankBlk | input | 20 | Transmit block index, four bits per bank |
| rxBankEn | input | 40 | Receive enable bits, eight per bank |
| rxBankBlk | input | 20 | Receive block index, four bits per bank |
| curChan | output | 7 | Current channel slot number |
| slotValid | output | 1 | A frame is in progress and curChan is a live slot |
| rxCapture | output | 1 | Capture the word of this slot |
| txDrive | output | 1 | Drive the transmit pin during this slot |
| txOverLimit | output | 1 | More than 32 transmit enables requested |
| rxOverLimit | output | 1 | More than 32 receive enables requested |

## Verification
The hardest states to reach from the ports are the last slot of a full 128-slot frame and the overrun that follows it. The bench gets there by walking a whole frame one wordStrobe at a time, with channel 127 enabled for transmit, and checks every slot on the way. The trimming of surplus enables is also hard to observe. The bench maps the fifth receive bank onto the lowest block and the first four banks onto higher blocks. If the cut were made by channel number instead of by bank order, the slots that end up selected would differ.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
  // Strobes from the control side to the slot datapath
  typedef struct packed {
    logic restart;  // load slot 0
    logic advance;  // step to next slot
  } slot_strobe_t;
endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_sel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameSync,
  input  logic         wordStrobe,
  input  logic         lastSlot,
  output slot_strobe_t strobe,
  output logic         slotValid
);
  logic inFrame;
  logic overrun;

  always_comb begin
    strobe.restart = frameSync;
    strobe.advance = wordStrobe && !frameSync && inFrame && !lastSlot;
    overrun        = wordStrobe && !frameSync && inFrame && lastSlot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               inFrame <= 1'b0;
    else if (strobe.restart) inFrame <= 1'b1;
    else if (overrun)        inFrame <= 1'b0;
  end

  assign slotValid = inFrame;
endmodule

// File: rtl/tdm_enable_limit.sv
module tdm_enable_limit #(
  parameter int NUM_CHAN  = 128,
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 5,
  parameter int MAX_EN    = 32
) (
  input  logic [NUM_BANKS*BANK_W-1:0]                    bankEn,
  input  logic [NUM_BANKS*$clog2(NUM_CHAN/BANK_W)-1:0]   bankBlk,
  output logic [NUM_CHAN-1:0]                            chanMask,
  output logic                                           overLimit
);
  localparam int BLK_W  = $clog2(NUM_CHAN / BANK_W);
  localparam int EN_BITS = NUM_BANKS * BANK_W;

  logic [EN_BITS-1:0] keep;
  int                 seen;

  // Honour set bits in bank-major order until the cap is reached
  always_comb begin
    keep = '0;
    seen = 0;
    for (int i = 0; i < EN_BITS; i++) begin
      if (bankEn[i]) begin
        if (seen < MAX_EN) keep[i] = 1'b1;
        seen = seen + 1;
      end
    end
    overLimit = (seen > MAX_EN);
  end

  // Scatter kept bits onto the channel map; shared blocks merge
  always_comb begin
    chanMask = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < BANK_W; k++) begin
        if (keep[b*BANK_W + k])
          chanMask[int'(bankBlk[b*BLK_W +: BLK_W])*BANK_W + k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_slot_datapath.sv
module tdm_slot_datapath
  import tdm_sel_pkg::*;
#(
  parameter int NUM_CHAN = 128,
  parameter int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  slot_strobe_t        strobe,
  input  logic                slotValid,
  input  logic [NUM_CHAN-1:0] txMask,
  input  logic [NUM_CHAN-1:0] rxMask,
  output logic [CHAN_W-1:0]   curChan,
  output logic                lastSlot,
  output logic                rxCapture,
  output logic                txDrive
);
  localparam logic [CHAN_W-1:0] LAST = CHAN_W'(NUM_CHAN - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               curChan <= '0;
    else if (strobe.restart) curChan <= '0;
    else if (strobe.advance) curChan <= curChan + CHAN_W'(1);
  end

  always_comb begin
    lastSlot  = (curChan == LAST);
    rxCapture = slotValid && rxMask[curChan];
    txDrive   = slotValid && txMask[curChan];
  end
endmodule

// File: rtl/tdm_slot_selector.sv
module tdm_slot_selector
  import tdm_sel_pkg::*;
#(
  parameter int NUM_CHAN  = 128,
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 5,
  parameter int MAX_EN    = 32,
  localparam int CHAN_W   = $clog2(NUM_CHAN),
  localparam int BLK_W    = $clog2(NUM_CHAN / BANK_W)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameSync,
  input  logic                          wordStrobe,
  input  logic [NUM_BANKS*BANK_W-1:0]   txBankEn,
  input  logic [NUM_BANKS*BLK_W-1:0]    txBankBlk,
  input  logic [NUM_BANKS*BANK_W-1:0]   rxBankEn,
  input  logic [NUM_BANKS*BLK_W-1:0]    rxBankBlk,
  output logic [CHAN_W-1:0]             curChan,
  output logic                          slotValid,
  output logic                          rxCapture,
  output logic                          txDrive,
  output logic                          txOverLimit,
  output logic                          rxOverLimit
);
  slot_strobe_t        strobe;
  logic                lastSlot;
  logic [NUM_CHAN-1:0] txMask;
  logic [NUM_CHAN-1:0] rxMask;

  tdm_slot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordStrobe(wordStrobe),
    .lastSlot(lastSlot), .strobe(strobe), .slotValid(slotValid)
  );

  tdm_enable_limit #(.NUM_CHAN(NUM_CHAN), .BANK_W(BANK_W),
                     .NUM_BANKS(NUM_BANKS), .MAX_EN(MAX_EN)) u_txLimit (
    .bankEn(txBankEn), .bankBlk(txBankBlk), .chanMask(txMask), .overLimit(txOverLimit)
  );

  tdm_enable_limit #(.NUM_CHAN(NUM_CHAN), .BANK_W(BANK_W),
                     .NUM_BANKS(NUM_BANKS), .MAX_EN(MAX_EN)) u_rxLimit (
    .bankEn(rxBankEn), .bankBlk(rxBankBlk), .chanMask(rxMask), .overLimit(rxOverLimit)
  );

  tdm_slot_datapath #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotValid(slotValid),
    .txMask(txMask), .rxMask(rxMask), .curChan(curChan), .lastSlot(lastSlot),
    .rxCapture(rxCapture), .txDrive(txDrive)
  );
endmodule

// File: rtl/tdm_slot_selector_chk.sv
module tdm_slot_selector_chk #(
  parameter int NUM_CHAN = 128,
  parameter int CHAN_W   = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameSync,
  input logic              wordStrobe,
  input logic [CHAN_W-1:0] curChan,
  input logic              slotValid,
  input logic              rxCapture,
  input logic              txDrive
);
  localparam logic [CHAN_W-1:0] LAST = CHAN_W'(NUM_CHAN - 1);

  p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (curChan == '0) && slotValid);

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && !frameSync && slotValid && curChan != LAST)
      |=> curChan == $past(curChan) + CHAN_W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && !(wordStrobe && slotValid)) |=> $stable(curChan));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |-> !rxCapture && !txDrive);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && !frameSync && slotValid && curChan == LAST)
      |=> !slotValid && curChan == LAST);
endmodule

bind tdm_slot_selector tdm_slot_selector_chk #(.NUM_CHAN(NUM_CHAN), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordStrobe(wordStrobe),
  .curChan(curChan), .slotValid(slotValid), .rxCapture(rxCapture), .txDrive(txDrive)
);

// File: tb/tdm_slot_selector_tb.sv
module tdm_slot_selector_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic        wordStrobe = 1'b0;
  logic [39:0] txBankEn = '0;
  logic [19:0] txBankBlk = '0;
  logic [39:0] rxBankEn = '0;
  logic [19:0] rxBankBlk = '0;
  logic [6:0]  curChan;
  logic        slotValid, rxCapture, txDrive, txOverLimit, rxOverLimit;

  int checks = 0;
  int failures = 0;
  logic [127:0] expRx, expTx;

  always #2.5 clk = ~clk;

  tdm_slot_selector u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordStrobe(wordStrobe),
    .txBankEn(txBankEn), .txBankBlk(txBankBlk), .rxBankEn(rxBankEn), .rxBankBlk(rxBankBlk),
    .curChan(curChan), .slotValid(slotValid), .rxCapture(rxCapture), .txDrive(txDrive),
    .txOverLimit(txOverLimit), .rxOverLimit(rxOverLimit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: apply strobes, cross one posedge, return at next negedge
  task automatic step(input logic fs, input logic ws);
    frameSync = fs; wordStrobe = ws;
    @(negedge clk);
    frameSync = 1'b0; wordStrobe = 1'b0;
  endtask

  task automatic setBank(input bit isTx, input int b, input logic [7:0] en, input logic [3:0] blk);
    if (isTx) begin txBankEn[b*8 +: 8] = en; txBankBlk[b*4 +: 4] = blk; end
    else      begin rxBankEn[b*8 +: 8] = en; rxBankBlk[b*4 +: 4] = blk; end
  endtask

  task automatic clearCfg();
    txBankEn = '0; txBankBlk = '0; rxBankEn = '0; rxBankBlk = '0;
    expRx = '0; expTx = '0;
  endtask

  // Start a frame and walk slots 0..lastCh, checking every slot
  task automatic walkFrame(input int lastCh, input string tag);
    step(1'b1, 1'b0);
    check({tag, " R2 slotValid after sync"}, int'(slotValid), 1);
    for (int ch = 0; ch <= lastCh; ch++) begin
      check({tag, " R3 curChan"}, int'(curChan), ch);
      check({tag, " R4 rxCapture"}, int'(rxCapture), int'(expRx[ch]));
      check({tag, " R5 txDrive"}, int'(txDrive), int'(expTx[ch]));
      if (ch != lastCh) step(1'b0, 1'b1);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 curChan", int'(curChan), 0);
    check("R1 slotValid", int'(slotValid), 0);
    check("R1 rxCapture", int'(rxCapture), 0);
    check("R1 txDrive", int'(txDrive), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testBeforeFrame();
    clearCfg();
    setBank(0, 0, 8'hFF, 4'd0);
    setBank(1, 0, 8'hFF, 4'd0);
    #0;
    check("R6 rxCapture before sync", int'(rxCapture), 0);
    check("R6 txDrive before sync", int'(txDrive), 0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R6 curChan ignores strobe", int'(curChan), 0);
    check("R6 slotValid", int'(slotValid), 0);
  endtask

  task automatic testBasic();
    clearCfg();
    setBank(0, 0, 8'b0000_0101, 4'd2);   // rx ch 16,18
    setBank(1, 1, 8'b0000_0010, 4'd2);   // tx ch 17
    expRx[16] = 1; expRx[18] = 1; expTx[17] = 1;
    walkFrame(20, "basic");
    check("basic R7 rx flag", int'(rxOverLimit), 0);
    step(1'b0, 1'b0);
    check("basic R3 hold", int'(curChan), 20);
  endtask

  task automatic testResync();
    clearCfg();
    setBank(0, 3, 8'h01, 4'd0);          // rx ch 0
    expRx[0] = 1;
    walkFrame(5, "resync");
    step(1'b1, 1'b1);                    // both strobes: sync wins
    check("R2 sync beats strobe", int'(curChan), 0);
    check("R2 rxCapture slot0", int'(rxCapture), 1);
    step(1'b0, 1'b1);
    check("R3 after resync", int'(curChan), 1);
  endtask

  task automatic testOverrun();
    clearCfg();
    setBank(1, 0, 8'h80, 4'd15);         // tx ch 127
    setBank(0, 4, 8'h80, 4'd15);         // rx ch 127
    expTx[127] = 1; expRx[127] = 1;
    walkFrame(127, "full");
    step(1'b0, 1'b1);
    check("R8 slotValid cleared", int'(slotValid), 0);
    check("R8 curChan holds", int'(curChan), 127);
    check("R8 txDrive off", int'(txDrive), 0);
    check("R8 rxCapture off", int'(rxCapture), 0);
    step(1'b0, 1'b1);
    check("R8 curChan still", int'(curChan), 127);
    step(1'b1, 1'b0);
    check("R8 sync recovers", int'(curChan), 0);
  endtask

  task automatic testLimit();
    clearCfg();
    // rx: 40 enables; bank 4 (last in order) maps to block 0 and is trimmed
    for (int b = 0; b < 4; b++) setBank(0, b, 8'hFF, 4'(b + 1));
    setBank(0, 4, 8'hFF, 4'd0);
    for (int c = 8; c < 40; c++) expRx[c] = 1;
    // tx: exactly 32 enables on blocks 5..8
    for (int b = 0; b < 4; b++) setBank(1, b, 8'hFF, 4'(b + 5));
    for (int c = 40; c < 72; c++) expTx[c] = 1;
    #0;
    check("R7 rx over limit", int'(rxOverLimit), 1);
    check("R7 tx at limit", int'(txOverLimit), 0);
    walkFrame(75, "limit R7");
    setBank(1, 4, 8'h01, 4'd0);          // 33rd tx enable
    #0;
    check("R7 tx now over", int'(txOverLimit), 1);
    step(1'b1, 1'b0);
    check("R7 trimmed tx slot0", int'(txDrive), 0);
  endtask

  task automatic testShared();
    clearCfg();
    setBank(0, 0, 8'h0F, 4'd3);
    setBank(0, 1, 8'hF0, 4'd3);
    setBank(0, 2, 8'h01, 4'd3);
    for (int c = 24; c < 32; c++) expRx[c] = 1;
    walkFrame(33, "shared R9");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    expRx = '0; expTx = '0;
    testReset();
    testBeforeFrame();
    testBasic();
    testResync();
    testOverrun();
    testLimit();
    testShared();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule